// File: doc/BRIEF.md
# Windowed Buffer Memory Port

This block gives a 16-bit host a path into a packet buffer RAM of up to 64 KB (a transmit area in the low 16 KB and a receive area above it) through one data window. The host first sets a byte start address and a direction. It then moves 16-bit words through the window. The buffer address steps by two bytes for each word. An eight-word FIFO sits between the window and the RAM. In write direction the FIFO collects host words and drains them into the RAM whenever the shared RAM port grants a cycle. In read direction it prefetches words ahead of the host until it is full, and it tops itself up as the host removes words.

The FIFO direction and its empty and full state are shown on three status pins. Any host operation the block cannot take yet is held off with a wait signal, so the host never receives stale data. A swap input exchanges the two bytes of every word as it passes between the window and the RAM. A target select can aim the same window at a small set of internal registers instead of the RAM: the six station address bytes, an 8-bit transmit end pointer, and a read-only product identifier.

Top module: `winBufPort`

## Requirements
- R1: After reset the direction is write (stDirRead=0), the FIFO is empty and not full, hostWait is low, and the buffer pointer is 0, so a window write with no address load lands in RAM word 0.
- R2: With tgtSel=0 (memory) in write direction, window words reach RAM in order, at word address (loaded byte address / 2) + n for the n-th word, and the pointer moves 2 bytes per word.
- R3: A window write in write direction while the FIFO holds 8 words raises hostWait until a RAM grant frees a slot; the word is then taken and no word is lost.
- R4: An address load, read command or write command issued while the write FIFO is not empty raises hostWait until the FIFO has drained, and only then takes effect.
- R5: A read command sets stDirRead=1 and prefetches words from the pointer until stFifoFull=1; window reads return the RAM words in address order, and prefetch continues as words are removed.
- R6: A window read in read direction with an empty FIFO raises hostWait until a prefetched word arrives, then returns that word.
- R7: An address load in read direction flushes the FIFO (stFifoEmpty=1 in the cycle after) and restarts prefetch at the new address.
- R8: With swapEn=1 the two bytes of each word are exchanged on the way to RAM and on the way back, so RAM holds {data[7:0],data[15:8]}.
- R9: The pointer wraps from byte address 0xFFFE to 0x0000.
- R10: A window write in read direction writes no RAM word and leaves the FIFO contents unchanged; a window read from memory in write direction returns 0 and changes nothing.
- R11: With tgtSel=1 the window reaches six station address bytes: each write stores data[7:0] and each read returns {8'h00, byte}, and both step an index 0..5. The index restarts at 0 whenever another target is selected. These accesses never wait and never touch RAM.
- R12: With tgtSel=2 the window reaches an 8-bit transmit end pointer: a write stores data[7:0], and a read returns it zero-extended.
- R13: With tgtSel=3 a window read returns the product identifier 0x00A3, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tgtSel | input | 2 | Window target: 0 memory, 1 station bytes, 2 transmit end pointer, 3 product identifier |
| swapEn | input | 1 | Exchange bytes between window and RAM |
| addrLoad | input | 1 | Load the buffer pointer from addrIn |
| addrIn | input | 16 | Buffer byte address |
| cmdRead | input | 1 | Switch to read direction and start prefetch |
| cmdWrite | input | 1 | Switch to write direction |
| winWr | input | 1 | Window write strobe |
| winWrData | input | 16 | Window write data |
| winRd | input | 1 | Window read strobe |
| winRdData | output | 16 | Window read data, valid while winRd is high and hostWait is low |
| hostWait | output | 1 | Current host operation is held; keep it asserted |
| stDirRead | output | 1 | FIFO direction, 1 = read |
| stFifoEmpty | output | 1 | FIFO empty |
| stFifoFull | output | 1 | FIFO full |
| ramGrant | input | 1 | RAM port is available this cycle |
| ramAddr | output | 15 | RAM word address |
| ramWe | output | 1 | RAM write enable |
| ramWrData | output | 16 | RAM write data |
| ramRe | output | 1 | RAM read enable; data is returned one cycle later |
| ramRdData | input | 16 | RAM read data |

## Verification
A wrong pointer or a wrong FIFO slot shows up at the ports on the first word that is out of place. On the write side it is a RAM write at an unexpected address or with unexpected data, one cycle after the word leaves the FIFO. On the read side it is a wrong word on the window. A lost or extra count in the FIFO bookkeeping shows up as a full or empty flag in the wrong cycle, or as a stall that never ends. Holding the RAM grant low makes these states stay still long enough to observe. An in-flight read that survives a flush returns data from the old address as the first word after an address load.

// File: rtl/winBufPkg.sv
package winBufPkg;

  typedef enum logic [1:0] {
    TGT_MEM   = 2'd0,
    TGT_STN   = 2'd1,
    TGT_TXEND = 2'd2,
    TGT_PID   = 2'd3
  } winTgt_e;

  typedef struct packed {
    logic push;
    logic pushFromRam;
    logic pop;
    logic flush;
    logic ptrLoad;
    logic ptrInc;
    logic stnWr;
    logic stnRd;
    logic stnIdxClr;
    logic txEndWr;
  } winStrobe_t;

endpackage

// File: rtl/winBufCtrl.sv
module winBufCtrl
  import winBufPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       tgtSel,
  input  logic             addrLoad,
  input  logic             cmdRead,
  input  logic             cmdWrite,
  input  logic             winWr,
  input  logic             winRd,
  input  logic             ramGrant,
  input  logic             fifoEmpty,
  input  logic             fifoFull,
  input  logic [CNT_W-1:0] fifoCnt,
  output winStrobe_t       strb,
  output logic             dirRead,
  output logic             hostWait,
  output logic             ramWe,
  output logic             ramRe
);

  localparam int SUM_W = CNT_W + 1;

  logic memSel;
  logic cmdOk;
  logic anyCmd;
  logic doAddr;
  logic doRead;
  logic doWrite;
  logic flush;
  logic hostPush;
  logic hostPop;
  logic drain;
  logic issue;
  logic land;
  logic room;
  logic pend;

  always_comb begin
    memSel   = (tgtSel == TGT_MEM);
    // control operations are taken only once a write FIFO has drained
    cmdOk    = dirRead | fifoEmpty;
    anyCmd   = addrLoad | cmdRead | cmdWrite;
    hostWait = (anyCmd & ~cmdOk)
             | (winWr & memSel & ~dirRead & fifoFull)
             | (winRd & memSel & dirRead & fifoEmpty);

    doAddr  = addrLoad & cmdOk;
    doRead  = cmdRead & cmdOk;
    doWrite = cmdWrite & cmdOk & ~cmdRead;
    flush   = dirRead & (doAddr | doRead | doWrite);

    hostPush = winWr & memSel & ~dirRead & ~fifoFull;
    hostPop  = winRd & memSel & dirRead & ~fifoEmpty & ~flush;

    // prefetch accounting counts the word already in flight
    room  = ({1'b0, fifoCnt} + SUM_W'(pend)) < SUM_W'(DEPTH);
    drain = ~dirRead & ~fifoEmpty & ramGrant;
    issue = dirRead & ~flush & ramGrant & room;
    land  = pend & ~flush;

    strb.push        = hostPush | land;
    strb.pushFromRam = dirRead;
    strb.pop         = drain | hostPop;
    strb.flush       = flush;
    strb.ptrLoad     = doAddr;
    strb.ptrInc      = drain | issue;
    strb.stnWr       = winWr & (tgtSel == TGT_STN);
    strb.stnRd       = winRd & (tgtSel == TGT_STN);
    strb.stnIdxClr   = (tgtSel != TGT_STN);
    strb.txEndWr     = winWr & (tgtSel == TGT_TXEND);

    ramWe = drain;
    ramRe = issue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirRead <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (doRead)       dirRead <= 1'b1;
      else if (doWrite) dirRead <= 1'b0;
      pend <= issue;
    end
  end

endmodule

// File: rtl/winBufDatapath.sv
module winBufDatapath
  import winBufPkg::*;
#(
  parameter int          AW         = 16,
  parameter int          DW         = 16,
  parameter int          DEPTH      = 8,
  parameter int          STN_BYTES  = 6,
  parameter int          TXEND_W    = 8,
  parameter logic [15:0] PRODUCT_ID = 16'h00A3,
  parameter int          CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  winStrobe_t       strb,
  input  logic [1:0]       tgtSel,
  input  logic             dirRead,
  input  logic             swapEn,
  input  logic [AW-1:0]    addrIn,
  input  logic [DW-1:0]    winWrData,
  input  logic [DW-1:0]    ramRdData,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic [CNT_W-1:0] fifoCnt,
  output logic [AW-2:0]    ramAddr,
  output logic [DW-1:0]    ramWrData,
  output logic [DW-1:0]    winRdData
);

  localparam int WA_W  = AW - 1;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IDX_W = (STN_BYTES > 1) ? $clog2(STN_BYTES) : 1;
  localparam int NB    = DW / 8;

  function automatic logic [DW-1:0] byteRev(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[8*b +: 8] = v[8*(NB-1-b) +: 8];
    return r;
  endfunction

  logic [DW-1:0]      fifoMem [DEPTH];
  logic [PTR_W-1:0]   rdPtr;
  logic [PTR_W-1:0]   wrPtr;
  logic [CNT_W-1:0]   cnt;
  logic [WA_W-1:0]    wordPtr;
  logic [7:0]         stnByte [STN_BYTES];
  logic [IDX_W-1:0]   stnIdx;
  logic [TXEND_W-1:0] txEnd;
  logic [DW-1:0]      pushData;
  logic [DW-1:0]      headWord;
  logic [DW-1:0]      memOut;

  always_comb begin
    pushData = strb.pushFromRam ? ramRdData
             : (swapEn ? byteRev(winWrData) : winWrData);
    headWord = fifoMem[rdPtr];
    memOut   = swapEn ? byteRev(headWord) : headWord;
  end

  // FIFO storage, one register row per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_fifoRow
    always_ff @(posedge clk) begin
      if (strb.push && !strb.flush && wrPtr == PTR_W'(g)) fifoMem[g] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else if (strb.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + PTR_W'(1);
      if (strb.pop)  rdPtr <= rdPtr + PTR_W'(1);
      cnt <= cnt + CNT_W'(strb.push) - CNT_W'(strb.pop);
    end
  end

  always_comb begin
    fifoCnt   = cnt;
    fifoEmpty = (cnt == '0);
    fifoFull  = (cnt == CNT_W'(DEPTH));
  end

  // buffer pointer holds a word address; byte bit 0 is dropped
  always_ff @(posedge clk) begin
    if (!rstN)             wordPtr <= '0;
    else if (strb.ptrLoad) wordPtr <= WA_W'(addrIn >> 1);
    else if (strb.ptrInc)  wordPtr <= wordPtr + WA_W'(1);
  end

  always_comb begin
    ramAddr   = wordPtr;
    ramWrData = headWord;
  end

  // station address bytes
  for (genvar g = 0; g < STN_BYTES; g++) begin : g_stnByte
    always_ff @(posedge clk) begin
      if (!rstN)                                   stnByte[g] <= '0;
      else if (strb.stnWr && stnIdx == IDX_W'(g))  stnByte[g] <= winWrData[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.stnIdxClr) begin
      stnIdx <= '0;
    end else if (strb.stnWr || strb.stnRd) begin
      if (stnIdx == IDX_W'(STN_BYTES - 1)) stnIdx <= '0;
      else                                 stnIdx <= stnIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             txEnd <= '0;
    else if (strb.txEndWr) txEnd <= winWrData[TXEND_W-1:0];
  end

  always_comb begin
    case (tgtSel)
      TGT_MEM:   winRdData = dirRead ? memOut : '0;
      TGT_STN:   winRdData = DW'(stnByte[stnIdx]);
      TGT_TXEND: winRdData = DW'(txEnd);
      default:   winRdData = DW'(PRODUCT_ID);
    endcase
  end

endmodule

// File: rtl/winBufPort.sv
module winBufPort
  import winBufPkg::*;
#(
  parameter int          AW         = 16,
  parameter int          DW         = 16,
  parameter int          DEPTH      = 8,
  parameter int          STN_BYTES  = 6,
  parameter int          TXEND_W    = 8,
  parameter logic [15:0] PRODUCT_ID = 16'h00A3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    tgtSel,
  input  logic          swapEn,
  input  logic          addrLoad,
  input  logic [AW-1:0] addrIn,
  input  logic          cmdRead,
  input  logic          cmdWrite,
  input  logic          winWr,
  input  logic [DW-1:0] winWrData,
  input  logic          winRd,
  output logic [DW-1:0] winRdData,
  output logic          hostWait,
  output logic          stDirRead,
  output logic          stFifoEmpty,
  output logic          stFifoFull,
  input  logic          ramGrant,
  output logic [AW-2:0] ramAddr,
  output logic          ramWe,
  output logic [DW-1:0] ramWrData,
  output logic          ramRe,
  input  logic [DW-1:0] ramRdData
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  winStrobe_t       strb;
  logic [CNT_W-1:0] fifoCnt;

  winBufCtrl #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tgtSel    (tgtSel),
    .addrLoad  (addrLoad),
    .cmdRead   (cmdRead),
    .cmdWrite  (cmdWrite),
    .winWr     (winWr),
    .winRd     (winRd),
    .ramGrant  (ramGrant),
    .fifoEmpty (stFifoEmpty),
    .fifoFull  (stFifoFull),
    .fifoCnt   (fifoCnt),
    .strb      (strb),
    .dirRead   (stDirRead),
    .hostWait  (hostWait),
    .ramWe     (ramWe),
    .ramRe     (ramRe)
  );

  winBufDatapath #(
    .AW         (AW),
    .DW         (DW),
    .DEPTH      (DEPTH),
    .STN_BYTES  (STN_BYTES),
    .TXEND_W    (TXEND_W),
    .PRODUCT_ID (PRODUCT_ID),
    .CNT_W      (CNT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .tgtSel    (tgtSel),
    .dirRead   (stDirRead),
    .swapEn    (swapEn),
    .addrIn    (addrIn),
    .winWrData (winWrData),
    .ramRdData (ramRdData),
    .fifoEmpty (stFifoEmpty),
    .fifoFull  (stFifoFull),
    .fifoCnt   (fifoCnt),
    .ramAddr   (ramAddr),
    .ramWrData (ramWrData),
    .winRdData (winRdData)
  );

endmodule

// File: rtl/winBufPortChk.sv
module winBufPortChk #(
  parameter int WA_W = 15
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      tgtSel,
  input logic            addrLoad,
  input logic            cmdRead,
  input logic            cmdWrite,
  input logic            winWr,
  input logic            winRd,
  input logic            hostWait,
  input logic            stDirRead,
  input logic            stFifoEmpty,
  input logic            stFifoFull,
  input logic [WA_W-1:0] ramAddr,
  input logic            ramWe,
  input logic            ramRe
);

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(stFifoFull && stFifoEmpty));

  p_no_write_in_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    stDirRead |-> !ramWe);

  p_no_fetch_in_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stDirRead |-> !ramRe);

  p_wait_when_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    (winWr && tgtSel == 2'd0 && !stDirRead && stFifoFull) |-> hostWait);

  p_wait_when_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (winRd && tgtSel == 2'd0 && stDirRead && stFifoEmpty) |-> hostWait);

  p_cmd_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((addrLoad || cmdRead || cmdWrite) && !stDirRead && !stFifoEmpty) |-> hostWait);

  p_flush_on_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (addrLoad && stDirRead) |=> stFifoEmpty);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && $past(ramWe) && !$past(addrLoad)) |-> ramAddr == $past(ramAddr) + WA_W'(1));

  p_other_no_wait_r11: assert property (@(posedge clk) disable iff (!rstN)
    (tgtSel != 2'd0 && !addrLoad && !cmdRead && !cmdWrite) |-> !hostWait);

endmodule

bind winBufPort winBufPortChk #(.WA_W(AW - 1)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .tgtSel      (tgtSel),
  .addrLoad    (addrLoad),
  .cmdRead     (cmdRead),
  .cmdWrite    (cmdWrite),
  .winWr       (winWr),
  .winRd       (winRd),
  .hostWait    (hostWait),
  .stDirRead   (stDirRead),
  .stFifoEmpty (stFifoEmpty),
  .stFifoFull  (stFifoFull),
  .ramAddr     (ramAddr),
  .ramWe       (ramWe),
  .ramRe       (ramRe)
);

// File: tb/winBufPort_tb_top.sv
`timescale 1ns/1ps
module winBufPort_tb_top;

  localparam int K_ADDR = 0;
  localparam int K_RCMD = 1;
  localparam int K_WCMD = 2;
  localparam int K_WWR  = 3;
  localparam int K_WRD  = 4;

  typedef struct packed {
    logic [15:0] addr;
    logic        swap;
    logic [7:0]  n;
    logic [15:0] seed;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{addr: 16'h0000, swap: 1'b0, n: 8'd5,  seed: 16'h1000},
    '{addr: 16'h3FF0, swap: 1'b1, n: 8'd12, seed: 16'hBE00},
    '{addr: 16'hFFFC, swap: 1'b0, n: 8'd6,  seed: 16'h0100},
    '{addr: 16'h8000, swap: 1'b1, n: 8'd20, seed: 16'h7700}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  tgtSel = 2'd0;
  logic        swapEn = 1'b0;
  logic        addrLoad = 1'b0;
  logic [15:0] addrIn = '0;
  logic        cmdRead = 1'b0;
  logic        cmdWrite = 1'b0;
  logic        winWr = 1'b0;
  logic [15:0] winWrData = '0;
  logic        winRd = 1'b0;
  logic [15:0] winRdData;
  logic        hostWait;
  logic        stDirRead;
  logic        stFifoEmpty;
  logic        stFifoFull;
  logic        ramGrant = 1'b1;
  logic [14:0] ramAddr;
  logic        ramWe;
  logic [15:0] ramWrData;
  logic        ramRe;
  logic [15:0] ramRdData = '0;

  int total = 0;
  int bad = 0;
  int weCount = 0;
  bit finished = 0;

  logic [15:0] mem [int];

  always #5 clk = ~clk;

  winBufPort dut_i (
    .clk(clk), .rstN(rstN), .tgtSel(tgtSel), .swapEn(swapEn),
    .addrLoad(addrLoad), .addrIn(addrIn), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
    .winWr(winWr), .winWrData(winWrData), .winRd(winRd), .winRdData(winRdData),
    .hostWait(hostWait), .stDirRead(stDirRead), .stFifoEmpty(stFifoEmpty),
    .stFifoFull(stFifoFull), .ramGrant(ramGrant), .ramAddr(ramAddr), .ramWe(ramWe),
    .ramWrData(ramWrData), .ramRe(ramRe), .ramRdData(ramRdData)
  );

  function automatic logic [15:0] memGet(input logic [14:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return {1'b0, a} ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] bswap(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  // RAM model: one-cycle read latency
  always @(posedge clk) begin
    if (ramWe) begin
      mem[int'(ramAddr)] = ramWrData;
      weCount++;
    end
    if (ramRe) ramRdData <= memGet(ramAddr);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostDo(input int kind, input logic [15:0] d, output logic [15:0] rd);
    @(negedge clk);
    case (kind)
      K_ADDR:  begin addrLoad = 1'b1; addrIn = d; end
      K_RCMD:  cmdRead = 1'b1;
      K_WCMD:  cmdWrite = 1'b1;
      K_WWR:   begin winWr = 1'b1; winWrData = d; end
      default: winRd = 1'b1;
    endcase
    #1;
    while (hostWait) begin
      @(negedge clk);
      #1;
    end
    rd = winRdData;
    @(negedge clk);
    addrLoad = 1'b0; cmdRead = 1'b0; cmdWrite = 1'b0; winWr = 1'b0; winRd = 1'b0;
  endtask

  task automatic waitEmpty();
    @(negedge clk);
    while (!stFifoEmpty) @(negedge clk);
  endtask

  task automatic waitFull();
    @(negedge clk);
    while (!stFifoFull) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int wc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 dir", stDirRead, 0);
    chk("R1 empty", stFifoEmpty, 1);
    chk("R1 full", stFifoFull, 0);
    chk("R1 wait", hostWait, 0);
    hostDo(K_WWR, 16'h0F0F, rd);
    waitEmpty();
    chk("R1 pointer zero", memGet(15'h0000), 16'h0F0F);

    // table walk: write, check RAM, read back
    for (int v = 0; v < 4; v++) begin
      string tag;
      logic [14:0] wa;
      tag = (v == 2) ? "R9" : (VECS[v].swap ? "R8" : "R2");
      hostDo(K_WCMD, 0, rd);
      hostDo(K_ADDR, VECS[v].addr, rd);
      @(negedge clk);
      swapEn = VECS[v].swap;
      for (int i = 0; i < int'(VECS[v].n); i++)
        hostDo(K_WWR, VECS[v].seed + 16'(i * 16'h0101), rd);
      waitEmpty();
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        logic [15:0] w;
        w = VECS[v].seed + 16'(i * 16'h0101);
        wa = VECS[v].addr[15:1] + 15'(i);
        chk(tag, memGet(wa), VECS[v].swap ? bswap(w) : w);
      end
      hostDo(K_ADDR, VECS[v].addr, rd);
      hostDo(K_RCMD, 0, rd);
      waitFull();
      chk("R5 full", stFifoFull, 1);
      chk("R5 dir", stDirRead, 1);
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        hostDo(K_WRD, 0, rd);
        chk("R5 readback", rd, VECS[v].seed + 16'(i * 16'h0101));
      end
    end
    @(negedge clk);
    swapEn = 1'b0;

    // R3: write stall at full
    hostDo(K_WCMD, 0, rd);
    hostDo(K_ADDR, 16'h1000, rd);
    @(negedge clk);
    ramGrant = 1'b0;
    for (int i = 0; i < 8; i++) hostDo(K_WWR, 16'hC000 + 16'(i), rd);
    #1;
    chk("R3 full", stFifoFull, 1);
    @(negedge clk);
    winWr = 1'b1;
    winWrData = 16'hC008;
    #1;
    chk("R3 wait", hostWait, 1);
    repeat (3) @(negedge clk);
    #1;
    chk("R3 still wait", hostWait, 1);
    ramGrant = 1'b1;
    #1;
    while (hostWait) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    winWr = 1'b0;
    waitEmpty();
    for (int i = 0; i < 9; i++)
      chk("R3 no loss", memGet(15'h0800 + 15'(i)), 16'hC000 + 16'(i));

    // R4: address load held until drained
    @(negedge clk);
    ramGrant = 1'b0;
    hostDo(K_WWR, 16'h5151, rd);
    hostDo(K_WWR, 16'h5252, rd);
    @(negedge clk);
    addrLoad = 1'b1;
    addrIn = 16'h2000;
    #1;
    chk("R4 wait", hostWait, 1);
    chk("R4 not empty", stFifoEmpty, 0);
    ramGrant = 1'b1;
    #1;
    while (hostWait) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    addrLoad = 1'b0;
    hostDo(K_WWR, 16'h4444, rd);
    waitEmpty();
    chk("R4 old words", memGet(15'h080A), 16'h5252);
    chk("R4 new addr", memGet(15'h1000), 16'h4444);

    // R6: read stall on empty
    @(negedge clk);
    ramGrant = 1'b0;
    hostDo(K_ADDR, 16'h2000, rd);
    hostDo(K_RCMD, 0, rd);
    #1;
    chk("R5 dir after cmd", stDirRead, 1);
    @(negedge clk);
    winRd = 1'b1;
    #1;
    chk("R6 wait", hostWait, 1);
    repeat (2) @(negedge clk);
    #1;
    chk("R6 still wait", hostWait, 1);
    ramGrant = 1'b1;
    #1;
    while (hostWait) begin
      @(negedge clk);
      #1;
    end
    chk("R6 data", winRdData, 16'h4444);
    @(negedge clk);
    winRd = 1'b0;
    hostDo(K_WRD, 0, rd);
    chk("R5 next word", rd, memGet(15'h1001));

    // R7: reload in read direction
    waitFull();
    hostDo(K_ADDR, 16'h0100, rd);
    chk("R7 flushed", stFifoEmpty, 1);
    for (int i = 0; i < 3; i++) begin
      hostDo(K_WRD, 0, rd);
      chk("R7 restart", rd, memGet(15'h0080 + 15'(i)));
    end

    // R10: writes ignored in read direction, reads zero in write direction
    wc = weCount;
    hostDo(K_WWR, 16'hDEAD, rd);
    hostDo(K_WRD, 0, rd);
    chk("R10 fifo intact", rd, memGet(15'h0083));
    chk("R10 no ram write", weCount, wc);
    hostDo(K_WCMD, 0, rd);
    hostDo(K_WRD, 0, rd);
    chk("R10 read zero", rd, 16'h0000);
    chk("R10 still empty", stFifoEmpty, 1);

    // R11: station bytes
    @(negedge clk);
    tgtSel = 2'd1;
    wc = weCount;
    for (int i = 0; i < 6; i++) hostDo(K_WWR, 16'hAB10 + 16'(i), rd);
    @(negedge clk);
    tgtSel = 2'd0;
    @(negedge clk);
    tgtSel = 2'd1;
    for (int i = 0; i < 6; i++) begin
      hostDo(K_WRD, 0, rd);
      chk("R11 byte", rd, 16'h0010 + 16'(i));
    end
    hostDo(K_WRD, 0, rd);
    chk("R11 index wrap", rd, 16'h0010);
    hostDo(K_WRD, 0, rd);
    @(negedge clk);
    tgtSel = 2'd2;
    @(negedge clk);
    tgtSel = 2'd1;
    hostDo(K_WRD, 0, rd);
    chk("R11 index restart", rd, 16'h0010);
    chk("R11 no ram", weCount, wc);

    // R12: transmit end pointer
    @(negedge clk);
    tgtSel = 2'd2;
    hostDo(K_WWR, 16'h1234, rd);
    hostDo(K_WRD, 0, rd);
    chk("R12 txend", rd, 16'h0034);

    // R13: product identifier
    @(negedge clk);
    tgtSel = 2'd3;
    hostDo(K_WRD, 0, rd);
    chk("R13 id", rd, 16'h00A3);
    hostDo(K_WWR, 16'hFFFF, rd);
    hostDo(K_WRD, 0, rd);
    chk("R13 id after write", rd, 16'h00A3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule